// File: doc/BRIEF.md
# Masked Configuration Register File

This block holds the 256-byte configuration space of a bus-attached function as 64 dwords. A single access port carries a dword index, four byte-lane enables, write data and a write strobe. The dword chosen by the index is always visible on the read port in the same cycle. A write lands on the next clock edge, but only in the bits that are both writable for that dword and inside an enabled byte lane.

The contents are fixed by parameters when the design is elaborated. These cover the vendor and device identity, the class triple, the subsystem identity, the interrupt pin, the header type, six address-window (BAR) slots and a short chain of capability structures. Each dword carries a writable mask that is fixed at elaboration. For a BAR, the mask is derived from the window size, so software can size a window by writing all ones and reading the value back. A synchronous reset reloads every dword from its parameter-derived value.

Top module: `cfg_space_regfile`

## Requirements
- R1: After reset, dword 0 reads {device ID, vendor ID} (device ID in bits 31:16). Dword 2 reads {class, subclass, programming interface, 8'h00}. Dword 11 reads {subsystem ID, subsystem vendor ID}. Dword 15 bits 15:8 hold the interrupt pin as a 1-based code (pin A = 1).
- R2: A read with an index of 64 to 127 returns 32'hFFFF_FFFF in the same cycle.
- R3: An accepted write with index i sets dword i to (old & ~m) | (wdata & m) at the next rising clock edge. Here m is the writable mask of dword i ANDed with the lane bits, where be[k] covers bits 8k+7:8k.
- R4: The accepted byte-enable patterns are a single lane (4'b0001, 4'b0010, 4'b0100 or 4'b1000), 4'b0011, 4'b1100 and 4'b1111. Any other pattern, including a 16-bit pair at offset 1 (4'b0110) or a 3-lane pattern, leaves every dword unchanged.
- R5: Dword 0 is fully read-only. Dword 1 is writable in bits 15:0 only. Dword 3 is writable in bits 7:0 only and reads 0 in bits 23:16 for header type 0. With header type 0, dword 15 is writable in bits 7:0 only.
- R6: BAR slot s sits in dword 4+s. A memory BAR's low nibble is 4'h8 when prefetchable, ORed with 4'h0 for a 32-bit window or 4'h4 for a 64-bit window. An I/O BAR has bit 0 set. Unused slots read 0 and cannot be written.
- R7: A BAR's writable mask is ~(size-1), so writing all ones reads back ~(size-1) together with the fixed low bits. For a 64-bit BAR, the next dword holds address bits 63:32 with mask ~((size-1)>>32).
- R8: When the capability chain is not empty, dword 1 bit 20 reads 1 and byte 0x34 reads 0x40. Each capability starts on the next dword boundary after the end of the previous one and starts with {next pointer, ID} in its low 16 bits. The last next pointer is 0. All of these bytes are read-only.
- R9: Writes to dwords that implement no field, and writes with an index of 64 or more, change no register.
- R10: A synchronous active-high reset reloads every dword from its parameter-derived value at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx | input | 7 | Dword index; 64 and above is outside the space |
| be | input | 4 | Byte-lane enables for a write |
| wdata | input | 32 | Write data, lane aligned |
| wr_en | input | 1 | Write strobe |
| rdata | output | 32 | Contents of the indexed dword (combinational) |

## Verification
A read result is due in the same cycle as its index: rdata depends only on idx and the register array. The bench changes idx one time unit after a rising edge and compares rdata at the following falling edge. A write becomes visible one edge after the strobe, so each write task holds the strobe across exactly one rising edge. The read of that dword is queued only after that edge. Reset reload is checked the same way: the read is queued in the cycle after reset is released.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int CFG_DWORDS = 64;
  localparam int DW_W       = $clog2(CFG_DWORDS);
  localparam int CFG_IDX_W  = DW_W + 1;
  localparam int NUM_BARS   = 6;
  localparam int BAR_DW0    = 4;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_MEM32 = 2'd1,
    WIN_MEM64 = 2'd2,
    WIN_IO    = 2'd3
  } win_kind_e;

  localparam logic [7:0] CHAIN_HEAD_BYTE = 8'h34;
  localparam logic [7:0] CHAIN_FIRST     = 8'h40;
  localparam int         CHAIN_LIMIT     = 192;

  function automatic logic [7:0] align_dw(input logic [7:0] b);
    return (b + 8'd3) & 8'hFC;
  endfunction
endpackage

// File: rtl/cfg_layout.sv
module cfg_layout
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR      = 16'hC0DE,
  parameter logic [15:0] DEVICE      = 16'h7A31,
  parameter logic [7:0]  CLASS_CODE  = 8'h04,
  parameter logic [7:0]  SUB_CLASS   = 8'h01,
  parameter logic [7:0]  PROG_IF     = 8'h5A,
  parameter logic [15:0] SUBSYS_VEN  = 16'hC0DE,
  parameter logic [15:0] SUBSYS_ID   = 16'h0042,
  parameter logic [7:0]  IRQ_PIN     = 8'h01,
  parameter bit          HDR_BRIDGE  = 1'b0,
  parameter logic [5:0][1:0]  WIN_KIND = {2'd0, 2'd0, 2'd3, 2'd0, 2'd2, 2'd1},
  parameter logic [5:0]       WIN_PREF = 6'b000010,
  parameter logic [5:0][63:0] WIN_SIZE = {64'h0, 64'h0, 64'h20, 64'h0, 64'h10000, 64'h1000},
  parameter logic [5:0][63:0] WIN_ADDR = {64'h0, 64'h0, 64'hC000, 64'h0, 64'h1_2340_0000, 64'hFEB0_0000},
  parameter int          MAX_CAPS    = 4,
  parameter int          NUM_CAPS    = 2,
  parameter logic [3:0][7:0]  CAP_ID  = {8'h0, 8'h0, 8'h05, 8'h09},
  parameter logic [3:0][7:0]  CAP_LEN = {8'h0, 8'h0, 8'h04, 8'h06},
  parameter logic [3:0][15:0] CAP_HI  = {16'h0, 16'h0, 16'h0081, 16'hBE06}
) (
  output logic [CFG_DWORDS-1:0][31:0] init_o,
  output logic [CFG_DWORDS-1:0][31:0] wmask_o
);

  function automatic logic [7:0] cap_at(input int k);
    logic [7:0] off;
    off = CHAIN_FIRST;
    for (int j = 0; j < MAX_CAPS; j++)
      if (j < k) off = align_dw(off + CAP_LEN[j]);
    return off;
  endfunction

  function automatic bit slot_live(input int s);
    return !HDR_BRIDGE || (s < 2);
  endfunction

  function automatic bit upper_half(input int s);
    return (s > 0) && slot_live(s) && (WIN_KIND[(s > 0) ? s - 1 : 0] == WIN_MEM64);
  endfunction

  function automatic logic [31:0] win_init(input int s);
    logic [63:0] a;
    a = WIN_ADDR[s];
    case (win_kind_e'(WIN_KIND[s]))
      WIN_MEM32: return (a[31:0] & 32'hFFFF_FFF0) | {28'h0, WIN_PREF[s], 3'b000};
      WIN_MEM64: return (a[31:0] & 32'hFFFF_FFF0) | {28'h0, WIN_PREF[s], 3'b100};
      WIN_IO:    return (a[31:0] & 32'hFFFF_FFFC) | 32'h1;
      default:   return upper_half(s) ? WIN_ADDR[s-1][63:32] : 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] win_mask(input int s);
    logic [63:0] m;
    m = WIN_SIZE[s] - 64'd1;
    if (WIN_KIND[s] != WIN_NONE) return ~m[31:0];
    if (upper_half(s)) begin
      m = WIN_SIZE[s-1] - 64'd1;
      return ~m[63:32];
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] calc_init(input int d);
    logic [31:0] v;
    v = 32'h0;
    case (d)
      0:  v = {DEVICE, VENDOR};
      1:  v = (NUM_CAPS > 0) ? 32'h0010_0000 : 32'h0;
      2:  v = {CLASS_CODE, SUB_CLASS, PROG_IF, 8'h00};
      3:  v = HDR_BRIDGE ? 32'h0001_0000 : 32'h0;
      11: v = {SUBSYS_ID, SUBSYS_VEN};
      13: v = (NUM_CAPS > 0) ? {24'h0, CHAIN_FIRST} : 32'h0;
      15: v = {16'h0, IRQ_PIN, 8'h00};
      default: v = 32'h0;
    endcase
    if (d >= BAR_DW0 && d < BAR_DW0 + NUM_BARS && slot_live(d - BAR_DW0))
      v = win_init(d - BAR_DW0);
    for (int k = 0; k < MAX_CAPS; k++)
      if (k < NUM_CAPS && int'(cap_at(k)) == 4 * d)
        v = {CAP_HI[k], (k == NUM_CAPS - 1) ? 8'h00 : cap_at(k + 1), CAP_ID[k]};
    return v;
  endfunction

  function automatic logic [31:0] calc_mask(input int d);
    logic [31:0] m;
    m = 32'h0;
    case (d)
      1:  m = 32'h0000_FFFF;
      3:  m = 32'h0000_00FF;
      15: m = HDR_BRIDGE ? 32'hFFFF_00FF : 32'h0000_00FF;
      default: m = 32'h0;
    endcase
    if (d >= BAR_DW0 && d < BAR_DW0 + NUM_BARS && slot_live(d - BAR_DW0))
      m = win_mask(d - BAR_DW0);
    if (HDR_BRIDGE && d == 9) m = 32'hFFF0_FFF0;
    return m;
  endfunction

  for (genvar s = 0; s < NUM_BARS; s++) begin : g_win_chk
    if (WIN_KIND[s] != WIN_NONE) begin : g_used
      if (WIN_SIZE[s] == 64'd0 || (WIN_SIZE[s] & (WIN_SIZE[s] - 64'd1)) != 64'd0) begin : g_pow2
        $error("window size of slot %0d is not a power of two", s);
      end
      if ((WIN_ADDR[s] & (WIN_SIZE[s] - 64'd1)) != 64'd0) begin : g_align
        $error("window address of slot %0d is not size aligned", s);
      end
      if (WIN_KIND[s] == WIN_MEM64 && s == NUM_BARS - 1) begin : g_last
        $error("64-bit window cannot sit in the last slot");
      end
      if (HDR_BRIDGE && (s > 1 || (s == 1 && WIN_KIND[s] == WIN_MEM64))) begin : g_bridge
        $error("bridge header has room for slots 0 and 1 only");
      end
    end
  end

  if (NUM_CAPS > MAX_CAPS) begin : g_cap_cnt
    $error("more capabilities than MAX_CAPS");
  end else if (NUM_CAPS > 0) begin : g_cap_fit
    if (int'(cap_at(NUM_CAPS - 1)) + int'(CAP_LEN[NUM_CAPS - 1]) > CHAIN_LIMIT) begin : g_full
      $error("capability chain runs past byte %0d", CHAIN_LIMIT);
    end
    for (genvar k = 0; k < NUM_CAPS; k++) begin : g_len
      if (CAP_LEN[k] < 8'd2) begin : g_short
        $error("capability %0d shorter than its header", k);
      end
    end
  end

  for (genvar d = 0; d < CFG_DWORDS; d++) begin : g_dw
    localparam logic [31:0] INIT_V = calc_init(d);
    localparam logic [31:0] MASK_V = calc_mask(d);
    assign init_o[d]  = INIT_V;
    assign wmask_o[d] = MASK_V;
  end

endmodule

// File: rtl/cfg_lane_decode.sv
module cfg_lane_decode (
  input  logic [3:0]  be,
  output logic        lane_ok,
  output logic [31:0] lane_bits
);
  always_comb begin
    case (be)
      4'b0001, 4'b0010, 4'b0100, 4'b1000,
      4'b0011, 4'b1100, 4'b1111: lane_ok = 1'b1;
      default:                   lane_ok = 1'b0;
    endcase
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_bits[8*k +: 8] = {8{be[k]}};
  end
endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR      = 16'hC0DE,
  parameter logic [15:0] DEVICE      = 16'h7A31,
  parameter logic [7:0]  CLASS_CODE  = 8'h04,
  parameter logic [7:0]  SUB_CLASS   = 8'h01,
  parameter logic [7:0]  PROG_IF     = 8'h5A,
  parameter logic [15:0] SUBSYS_VEN  = 16'hC0DE,
  parameter logic [15:0] SUBSYS_ID   = 16'h0042,
  parameter logic [7:0]  IRQ_PIN     = 8'h01,
  parameter bit          HDR_BRIDGE  = 1'b0,
  parameter logic [5:0][1:0]  WIN_KIND = {2'd0, 2'd0, 2'd3, 2'd0, 2'd2, 2'd1},
  parameter logic [5:0]       WIN_PREF = 6'b000010,
  parameter logic [5:0][63:0] WIN_SIZE = {64'h0, 64'h0, 64'h20, 64'h0, 64'h10000, 64'h1000},
  parameter logic [5:0][63:0] WIN_ADDR = {64'h0, 64'h0, 64'hC000, 64'h0, 64'h1_2340_0000, 64'hFEB0_0000},
  parameter int          MAX_CAPS    = 4,
  parameter int          NUM_CAPS    = 2,
  parameter logic [3:0][7:0]  CAP_ID  = {8'h0, 8'h0, 8'h05, 8'h09},
  parameter logic [3:0][7:0]  CAP_LEN = {8'h0, 8'h0, 8'h04, 8'h06},
  parameter logic [3:0][15:0] CAP_HI  = {16'h0, 16'h0, 16'h0081, 16'hBE06}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CFG_IDX_W-1:0] idx,
  input  logic [3:0]           be,
  input  logic [31:0]          wdata,
  input  logic                 wr_en,
  output logic [31:0]          rdata
);

  logic [CFG_DWORDS-1:0][31:0] init_w;
  logic [CFG_DWORDS-1:0][31:0] wmask_w;
  logic [CFG_DWORDS-1:0][31:0] regs_q;
  logic                        lane_ok;
  logic [31:0]                 lane_bits;
  logic                        in_range;
  logic [DW_W-1:0]             slot;
  logic [31:0]                 eff_mask;

  cfg_layout #(
    .VENDOR(VENDOR), .DEVICE(DEVICE), .CLASS_CODE(CLASS_CODE),
    .SUB_CLASS(SUB_CLASS), .PROG_IF(PROG_IF), .SUBSYS_VEN(SUBSYS_VEN),
    .SUBSYS_ID(SUBSYS_ID), .IRQ_PIN(IRQ_PIN), .HDR_BRIDGE(HDR_BRIDGE),
    .WIN_KIND(WIN_KIND), .WIN_PREF(WIN_PREF), .WIN_SIZE(WIN_SIZE),
    .WIN_ADDR(WIN_ADDR), .MAX_CAPS(MAX_CAPS), .NUM_CAPS(NUM_CAPS),
    .CAP_ID(CAP_ID), .CAP_LEN(CAP_LEN), .CAP_HI(CAP_HI)
  ) u_layout (
    .init_o  (init_w),
    .wmask_o (wmask_w)
  );

  cfg_lane_decode u_lanes (
    .be        (be),
    .lane_ok   (lane_ok),
    .lane_bits (lane_bits)
  );

  assign in_range = (idx < CFG_IDX_W'(CFG_DWORDS));
  assign slot     = idx[DW_W-1:0];
  assign eff_mask = wmask_w[slot] & lane_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= init_w;
    end else if (wr_en && in_range && lane_ok) begin
      regs_q[slot] <= (regs_q[slot] & ~eff_mask) | (wdata & eff_mask);
    end
  end

  assign rdata = in_range ? regs_q[slot] : 32'hFFFF_FFFF;

endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk
  import cfg_space_pkg::*;
(
  input logic                        clk,
  input logic                        rst,
  input logic [CFG_IDX_W-1:0]        idx,
  input logic [3:0]                  be,
  input logic                        wr_en,
  input logic [31:0]                 rdata,
  input logic [CFG_DWORDS-1:0][31:0] regs_q,
  input logic [CFG_DWORDS-1:0][31:0] wmask,
  input logic [CFG_DWORDS-1:0][31:0] init
);

  // R2
  oob_read_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (idx >= CFG_IDX_W'(CFG_DWORDS)) |-> (rdata == 32'hFFFF_FFFF));

  // R3
  masked_bits_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx < CFG_IDX_W'(CFG_DWORDS)) |=>
      (((regs_q[$past(idx[DW_W-1:0])] ^ $past(regs_q[idx[DW_W-1:0]]))
        & ~$past(wmask[idx[DW_W-1:0]])) == 32'h0));

  // R4
  odd_lanes_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ($countones(be) == 3 || be == 4'b0110)) |=> $stable(regs_q));

  // R5
  ident_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(regs_q[0]));

  // R9
  oob_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx >= CFG_IDX_W'(CFG_DWORDS)) |=> $stable(regs_q));

  // R10
  reset_reload_chk: assert property (@(posedge clk)
    rst |=> (regs_q == init));

endmodule

bind cfg_space_regfile cfg_space_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .idx    (idx),
  .be     (be),
  .wr_en  (wr_en),
  .rdata  (rdata),
  .regs_q (regs_q),
  .wmask  (wmask_w),
  .init   (init_w)
);

// File: tb/test_cfg_space_regfile.sv
`timescale 1ns/1ps
module test_cfg_space_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  idx = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [6:0]  idx;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  always #2.5 clk = ~clk;

  cfg_space_regfile i_cfg_space_regfile (
    .clk(clk), .rst(rst), .idx(idx), .be(be),
    .wdata(wdata), .wr_en(wr_en), .rdata(rdata)
  );

  // Monitor: compares at the falling edge after the driver set idx
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        errors++;
        $display("FAIL %s idx=%0d actual=%h expected=%h", it.tag, it.idx, rdata, it.exp);
      end
    end
  end

  task automatic expect_rd(input logic [6:0] i, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    wr_en = 1'b0;
    idx = i;
    it.idx = i; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic do_wr(input logic [6:0] i, input logic [3:0] b, input logic [31:0] d);
    @(posedge clk); #1;
    idx = i; be = b; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; be = '0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;

    // R1 identity after reset
    expect_rd(7'd0,  32'h7A31_C0DE, "R1 ids");
    expect_rd(7'd2,  32'h0401_5A00, "R1 class");
    expect_rd(7'd11, 32'h0042_C0DE, "R1 subsystem");
    expect_rd(7'd15, 32'h0000_0100, "R1 irq pin");
    // R5 header type 0 in dword 3
    expect_rd(7'd3,  32'h0000_0000, "R5 header");
    // R8 capability chain
    expect_rd(7'd1,  32'h0010_0000, "R8 status cap bit");
    expect_rd(7'd13, 32'h0000_0040, "R8 head pointer");
    expect_rd(7'd16, 32'hBE06_4809, "R8 cap0 header");
    expect_rd(7'd17, 32'h0000_0000, "R8 cap0 tail");
    expect_rd(7'd18, 32'h0081_0005, "R8 cap1 last");
    // R6 BAR encodings
    expect_rd(7'd4,  32'hFEB0_0000, "R6 mem32");
    expect_rd(7'd5,  32'h2340_000C, "R6 mem64 pref");
    expect_rd(7'd6,  32'h0000_0001, "R6 mem64 upper");
    expect_rd(7'd7,  32'h0000_C001, "R6 io");
    expect_rd(7'd8,  32'h0000_0000, "R6 unused slot");
    // R2 out-of-range reads
    expect_rd(7'd64,  32'hFFFF_FFFF, "R2 idx64");
    expect_rd(7'd127, 32'hFFFF_FFFF, "R2 idx127");

    // R5 read-only identity
    do_wr(7'd0, 4'b1111, 32'hBAAD_F00D);
    expect_rd(7'd0, 32'h7A31_C0DE, "R5 ids read-only");
    // R3/R5 command writable, status not
    do_wr(7'd1, 4'b1111, 32'hFFFF_FFFF);
    expect_rd(7'd1, 32'h0010_FFFF, "R3 command write");
    // R7 BAR sizing
    do_wr(7'd4, 4'b1111, 32'hFFFF_FFFF);
    expect_rd(7'd4, 32'hFFFF_F000, "R7 mem32 size");
    do_wr(7'd5, 4'b1111, 32'hFFFF_FFFF);
    expect_rd(7'd5, 32'hFFFF_000C, "R7 mem64 size");
    do_wr(7'd6, 4'b1111, 32'hFFFF_FFFF);
    expect_rd(7'd6, 32'hFFFF_FFFF, "R7 upper mask");
    do_wr(7'd6, 4'b1111, 32'h0000_0002);
    expect_rd(7'd6, 32'h0000_0002, "R7 upper addr");
    do_wr(7'd7, 4'b1111, 32'hFFFF_FFFF);
    expect_rd(7'd7, 32'hFFFF_FFE1, "R7 io size");
    do_wr(7'd8, 4'b1111, 32'hFFFF_FFFF);
    expect_rd(7'd8, 32'h0000_0000, "R6 unused slot write");

    // R3 byte lanes on dword 3
    do_wr(7'd3, 4'b0001, 32'h1234_5678);
    expect_rd(7'd3, 32'h0000_0078, "R3 byte lane0");
    do_wr(7'd3, 4'b0010, 32'hFFFF_FFFF);
    expect_rd(7'd3, 32'h0000_0078, "R5 dword3 lane1 ro");

    // R4 accepted and rejected patterns on dword 1
    do_wr(7'd1, 4'b0110, 32'h0000_0000);
    expect_rd(7'd1, 32'h0010_FFFF, "R4 pair at offset1");
    do_wr(7'd1, 4'b0011, 32'h0000_1234);
    expect_rd(7'd1, 32'h0010_1234, "R4 low pair");
    do_wr(7'd1, 4'b0010, 32'h0000_AB00);
    expect_rd(7'd1, 32'h0010_AB34, "R4 single byte1");
    do_wr(7'd1, 4'b1100, 32'h0000_0000);
    expect_rd(7'd1, 32'h0010_AB34, "R5 status ro");
    do_wr(7'd15, 4'b0111, 32'h0000_0055);
    expect_rd(7'd15, 32'h0000_0100, "R4 three lanes");
    do_wr(7'd15, 4'b1111, 32'hFFFF_FF3C);
    expect_rd(7'd15, 32'h0000_013C, "R5 irq line only");

    // R8 chain is read-only
    do_wr(7'd13, 4'b1111, 32'hFFFF_FFFF);
    expect_rd(7'd13, 32'h0000_0040, "R8 head ro");
    do_wr(7'd16, 4'b1111, 32'h0000_0000);
    expect_rd(7'd16, 32'hBE06_4809, "R8 cap ro");

    // R9 unimplemented and out-of-range writes
    do_wr(7'd30, 4'b1111, 32'hFFFF_FFFF);
    expect_rd(7'd30, 32'h0000_0000, "R9 unimplemented");
    do_wr(7'd100, 4'b1111, 32'hFFFF_FFFF);
    expect_rd(7'd36, 32'h0000_0000, "R9 no alias");
    expect_rd(7'd100, 32'hFFFF_FFFF, "R9 oob read");

    // R10 reset reload
    do_reset();
    expect_rd(7'd4, 32'hFEB0_0000, "R10 bar reload");
    expect_rd(7'd1, 32'h0010_0000, "R10 command reload");
    expect_rd(7'd15, 32'h0000_0100, "R10 line reload");
    expect_rd(7'd3, 32'h0000_0000, "R10 cls reload");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule